// File: doc/BRIEF.md
# Interrupt Eligibility Mask Unit

This block keeps the per-line state for a bank of interrupt lines and turns it, every cycle, into a mask that marks which lines may be offered to a processor. The stored state for each line is a pending latch, a trigger mode (edge or level), a synchronised copy of the line, an enable bit, an active bit, a group bit and a group-modifier bit. A small control register holds the three group enables and a security-off bit. The priority picker that follows this block consumes the mask. The same bank is used for the shared lines and for each processor's private lines.

A line is a candidate when its latch is set or when it is in level mode and its sampled input is high. A candidate must also be enabled and not active. Its class must also be open. Group bit 1 is the non-secure group 1 class. Group bit 0 with modifier 1 is the secure group 1 class. Group bit 0 with modifier 0 is group 0. When the security-off bit is set, every modifier counts as 0.

The latch, enable and active bits each have a write-1-to-set port and a write-1-to-clear port. Mode, group and modifier are written whole under a write strobe. In edge mode, a rising edge on a line sets its latch.

Top module: `irq_elig_bank`

## Requirements
- R1: While reset is high, and after it is released, all stored state and `elig_mask` are zero.
- R2: In level mode (`trig` bit 0), a line with a clear latch is eligible while its sampled input is 1 and not eligible once the input returns to 0. The input does not set the latch.
- R3: In edge mode (`trig` bit 1), a 0-to-1 change on a line sets its latch, which stays set after the line falls. A line held high does not count as pending once its latch has been cleared.
- R4: For each of the latch, enable and active bits, a 1 on the set port sets the bit and a 1 on the clear port clears it. A set and a clear of the same bit in the same cycle leave the bit set. This also holds when the set comes from a detected edge.
- R5: A line whose enable bit is 0 is never eligible.
- R6: A line whose active bit is 1 is never eligible. Clearing the active bit makes the line eligible again if its other conditions hold.
- R7: With control bit 2 (non-secure group 1 enable) set, lines with group bit 1 are allowed. With bits 0 to 2 all clear, no line is eligible.
- R8: With control bit 1 (secure group 1 enable) set, lines with group bit 0 and modifier bit 1 are allowed.
- R9: With control bit 0 (group 0 enable) set, lines with group bit 0 and modifier bit 0 are allowed. The mask is the union over all enabled classes.
- R10: With control bit 3 (security off) set, every modifier bit is taken as 0. A group-0 line with modifier 1 then follows the group 0 enable, not the secure group 1 enable.
- R11: A write or input change presented before clock edge k updates the state at edge k. `elig_mask` reflects it at edge k+1 and still shows the previous result between edges k and k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N | Raw interrupt lines |
| pend_set | input | N | Write-1-to-set for pending latches |
| pend_clr | input | N | Write-1-to-clear for pending latches |
| en_set | input | N | Write-1-to-set for enable bits |
| en_clr | input | N | Write-1-to-clear for enable bits |
| act_set | input | N | Write-1-to-set for active bits |
| act_clr | input | N | Write-1-to-clear for active bits |
| trig_we | input | 1 | Write strobe for trigger modes |
| trig_wdata | input | N | Trigger modes, 1 = edge, 0 = level |
| grp_we | input | 1 | Write strobe for group bits |
| grp_wdata | input | N | Group bits |
| gmod_we | input | 1 | Write strobe for group-modifier bits |
| gmod_wdata | input | N | Group-modifier bits |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 4 | bit0 group 0 enable, bit1 secure group 1 enable, bit2 non-secure group 1 enable, bit3 security off |
| elig_mask | output | N | Registered eligibility mask |

## Verification
Every stimulus is applied on a falling edge and reaches the state registers on the next rising edge, k. The mask follows on edge k+1. After each stimulus, the bench samples on the falling edge between k and k+1 and expects the old mask. It samples again one full cycle later and expects the new mask. Expected masks come from shadow copies of the state, updated by the set-over-clear and edge rules. A 32-line pattern spans every combination of group, modifier, enable, active and latch, and the bench sweeps it through all sixteen control values.

// File: rtl/irq_elig_pkg.sv
package irq_elig_pkg;

    typedef struct packed {
        logic sec_off;
        logic ns_g1_en;
        logic s_g1_en;
        logic g0_en;
    } elig_ctrl_t;

    localparam int CTRL_W = $bits(elig_ctrl_t);

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    typedef struct packed {
        logic  latch;
        trig_e trig;
        logic  lvl;
        logic  en;
        logic  act;
        logic  grp;
        logic  gmod;
    } line_state_t;

    function automatic logic raw_pending(line_state_t s);
        return s.latch | ((s.trig == TRIG_LEVEL) & s.lvl);
    endfunction

    function automatic logic class_open(elig_ctrl_t c, logic grp, logic gmod);
        logic m;
        m = gmod & ~c.sec_off;
        return (c.ns_g1_en & grp)
             | (c.s_g1_en  & ~grp &  m)
             | (c.g0_en    & ~grp & ~m);
    endfunction

    function automatic logic line_eligible(line_state_t s, elig_ctrl_t c);
        return raw_pending(s) & s.en & ~s.act & class_open(c, s.grp, s.gmod);
    endfunction

endpackage

// File: rtl/irq_sc_reg.sv
module irq_sc_reg #(
    parameter int N        = 32,
    parameter bit SET_WINS = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] nxt;

    generate
        if (SET_WINS) begin : g_set_wins
            always_comb nxt = (q_o & ~clr_i) | set_i;
        end else begin : g_clr_wins
            always_comb nxt = (q_o | set_i) & ~clr_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= nxt;
    end
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)       q_o <= '0;
        else if (we_i) q_o <= d_i;
    end
endmodule

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o
);
    always_ff @(posedge clk) begin
        if (rst) lvl_o <= '0;
        else     lvl_o <= line_i;
    end

    assign rise_o = line_i & ~lvl_o;
endmodule

// File: rtl/irq_elig_calc.sv
module irq_elig_calc
    import irq_elig_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      latch_i,
    input  logic [N-1:0]      trig_i,
    input  logic [N-1:0]      lvl_i,
    input  logic [N-1:0]      en_i,
    input  logic [N-1:0]      act_i,
    input  logic [N-1:0]      grp_i,
    input  logic [N-1:0]      gmod_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [N-1:0]      mask_o
);
    elig_ctrl_t   ctrl;
    logic [N-1:0] mask_d;

    assign ctrl = elig_ctrl_t'(ctrl_i);

    for (genvar i = 0; i < N; i++) begin : g_line
        line_state_t st;
        always_comb begin
            st.latch = latch_i[i];
            st.trig  = trig_e'(trig_i[i]);
            st.lvl   = lvl_i[i];
            st.en    = en_i[i];
            st.act   = act_i[i];
            st.grp   = grp_i[i];
            st.gmod  = gmod_i[i];
            mask_d[i] = line_eligible(st, ctrl);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mask_o <= '0;
        else     mask_o <= mask_d;
    end
endmodule

// File: rtl/irq_elig_bank.sv
module irq_elig_bank
    import irq_elig_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      irq_in,
    input  logic [N-1:0]      pend_set,
    input  logic [N-1:0]      pend_clr,
    input  logic [N-1:0]      en_set,
    input  logic [N-1:0]      en_clr,
    input  logic [N-1:0]      act_set,
    input  logic [N-1:0]      act_clr,
    input  logic              trig_we,
    input  logic [N-1:0]      trig_wdata,
    input  logic              grp_we,
    input  logic [N-1:0]      grp_wdata,
    input  logic              gmod_we,
    input  logic [N-1:0]      gmod_wdata,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [N-1:0]      elig_mask
);
    logic [N-1:0]      lvl_q, rise;
    logic [N-1:0]      pend_q, en_q, act_q;
    logic [N-1:0]      trig_q, grp_q, gmod_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [N-1:0]      pend_set_all;

    irq_edge_sync #(.N(N)) u_sync (
        .clk(clk), .rst(rst), .line_i(irq_in), .lvl_o(lvl_q), .rise_o(rise)
    );

    assign pend_set_all = pend_set | (rise & trig_q);

    irq_sc_reg #(.N(N), .SET_WINS(1'b1)) u_pend (
        .clk(clk), .rst(rst), .set_i(pend_set_all), .clr_i(pend_clr), .q_o(pend_q)
    );
    irq_sc_reg #(.N(N), .SET_WINS(1'b1)) u_en (
        .clk(clk), .rst(rst), .set_i(en_set), .clr_i(en_clr), .q_o(en_q)
    );
    irq_sc_reg #(.N(N), .SET_WINS(1'b1)) u_act (
        .clk(clk), .rst(rst), .set_i(act_set), .clr_i(act_clr), .q_o(act_q)
    );

    irq_cfg_reg #(.W(N)) u_trig (
        .clk(clk), .rst(rst), .we_i(trig_we), .d_i(trig_wdata), .q_o(trig_q)
    );
    irq_cfg_reg #(.W(N)) u_grp (
        .clk(clk), .rst(rst), .we_i(grp_we), .d_i(grp_wdata), .q_o(grp_q)
    );
    irq_cfg_reg #(.W(N)) u_gmod (
        .clk(clk), .rst(rst), .we_i(gmod_we), .d_i(gmod_wdata), .q_o(gmod_q)
    );
    irq_cfg_reg #(.W(CTRL_W)) u_ctrl (
        .clk(clk), .rst(rst), .we_i(ctrl_we), .d_i(ctrl_wdata), .q_o(ctrl_q)
    );

    irq_elig_calc #(.N(N)) u_calc (
        .clk(clk), .rst(rst),
        .latch_i(pend_q), .trig_i(trig_q), .lvl_i(lvl_q),
        .en_i(en_q), .act_i(act_q), .grp_i(grp_q), .gmod_i(gmod_q),
        .ctrl_i(ctrl_q), .mask_o(elig_mask)
    );
endmodule

// File: rtl/irq_elig_checker.sv
module irq_elig_checker #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] pend_set,
    input logic [N-1:0] pend_q,
    input logic [N-1:0] en_set,
    input logic [N-1:0] en_clr,
    input logic [N-1:0] en_q,
    input logic [N-1:0] act_q,
    input logic [3:0]   ctrl_q,
    input logic [N-1:0] elig_mask
);
    logic past_ok;
    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst_d == 1'b1) begin
            AST_RESET_MASK: assert (elig_mask == '0); // R1
        end
    end

    AST_PEND_SET_WINS: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (($past(pend_set) & ~pend_q) == '0)); // R4

    AST_EN_CLEARED: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (($past(en_clr & ~en_set) & en_q) == '0)); // R4

    AST_EN_GATES: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ((elig_mask & ~$past(en_q)) == '0)); // R5

    AST_ACTIVE_BLOCKS: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ((elig_mask & $past(act_q)) == '0)); // R6

    AST_NO_CLASS_OPEN: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(ctrl_q[2:0]) == 3'b000) |-> (elig_mask == '0)); // R7
endmodule

bind irq_elig_bank irq_elig_checker #(.N(N)) u_chk (
    .clk(clk), .rst(rst),
    .pend_set(pend_set), .pend_q(pend_q),
    .en_set(en_set), .en_clr(en_clr), .en_q(en_q),
    .act_q(act_q), .ctrl_q(ctrl_q), .elig_mask(elig_mask)
);

// File: tb/test_irq_elig_bank.sv
module test_irq_elig_bank;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_in = '0, pend_set = '0, pend_clr = '0;
    logic [N-1:0] en_set = '0, en_clr = '0, act_set = '0, act_clr = '0;
    logic         trig_we = 1'b0, grp_we = 1'b0, gmod_we = 1'b0, ctrl_we = 1'b0;
    logic [N-1:0] trig_wdata = '0, grp_wdata = '0, gmod_wdata = '0;
    logic [3:0]   ctrl_wdata = '0;
    logic [N-1:0] elig_mask;

    logic [N-1:0] b_pend = '0, b_en = '0, b_act = '0, b_trig = '0;
    logic [N-1:0] b_grp = '0, b_gmod = '0, b_lvl = '0;
    logic [3:0]   b_ctrl = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    irq_elig_bank #(.N(N)) i_irq_elig_bank (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .pend_set(pend_set), .pend_clr(pend_clr),
        .en_set(en_set), .en_clr(en_clr), .act_set(act_set), .act_clr(act_clr),
        .trig_we(trig_we), .trig_wdata(trig_wdata),
        .grp_we(grp_we), .grp_wdata(grp_wdata),
        .gmod_we(gmod_we), .gmod_wdata(gmod_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .elig_mask(elig_mask)
    );

    always #10ns clk = ~clk;

    function automatic logic [N-1:0] model();
        logic [N-1:0] m, allow;
        m     = b_gmod & {N{~b_ctrl[3]}};
        allow = ({N{b_ctrl[2]}} & b_grp)
              | ({N{b_ctrl[1]}} & ~b_grp & m)
              | ({N{b_ctrl[0]}} & ~b_grp & ~m);
        return (b_pend | (~b_trig & b_lvl)) & b_en & ~b_act & allow;
    endfunction

    task automatic chk(string req, logic [N-1:0] exp);
        checks++;
        if (elig_mask !== exp) begin
            errors++;
            $display("FAIL %s: elig_mask=%h expected %h", req, elig_mask, exp);
        end
    endtask

    task automatic commit(string req);
        logic [N-1:0] old_exp;
        old_exp = model();
        @(posedge clk);
        b_pend = (b_pend & ~pend_clr) | pend_set | (irq_in & ~b_lvl & b_trig);
        b_en   = (b_en & ~en_clr) | en_set;
        b_act  = (b_act & ~act_clr) | act_set;
        if (trig_we) b_trig = trig_wdata;
        if (grp_we)  b_grp  = grp_wdata;
        if (gmod_we) b_gmod = gmod_wdata;
        if (ctrl_we) b_ctrl = ctrl_wdata;
        b_lvl = irq_in;
        #1ns;
        pend_set = '0; pend_clr = '0; en_set = '0; en_clr = '0;
        act_set = '0; act_clr = '0;
        trig_we = 1'b0; grp_we = 1'b0; gmod_we = 1'b0; ctrl_we = 1'b0;
        @(negedge clk);
        chk("R11 (old value before edge k+1)", old_exp);
        @(posedge clk);
        @(negedge clk);
        chk(req, model());
    endtask

    initial begin
        #4ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11: watchdog expired, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 in reset", '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", '0);

        // Pattern covering every combination: bit i -> grp=i[0], gmod=i[1], en=i[2], act=i[3], latch=i[4]
        trig_we = 1'b1; trig_wdata = '1;
        grp_we = 1'b1; gmod_we = 1'b1;
        for (int i = 0; i < N; i++) begin
            grp_wdata[i]  = i[0];
            gmod_wdata[i] = i[1];
            en_set[i]     = i[2];
            act_set[i]    = i[3];
            pend_set[i]   = i[4];
        end
        commit("R7 closed classes");

        for (int c = 0; c < 16; c++) begin
            ctrl_we = 1'b1; ctrl_wdata = 4'(c);
            if (c >= 8) commit("R10");
            else        commit("R5/R6/R7/R8/R9");
        end

        ctrl_we = 1'b1; ctrl_wdata = 4'b0111; commit("R9 union");
        pend_clr = '1; commit("R4 latch clear");
        pend_set = 32'h0000_FFFF; pend_clr = '1; commit("R4 latch set wins");
        en_set = 32'hFF00_FF00; en_clr = 32'hFF00_FF00; commit("R4 enable set wins");
        en_clr = 32'h0000_00FF; commit("R5 enable cleared");
        act_clr = '1; commit("R6 active cleared");
        act_set = 32'h0000_F0F0; commit("R6 active set");

        act_clr = '1; en_set = '1; pend_clr = '1;
        trig_we = 1'b1; trig_wdata = '0; commit("R2 level mode setup");
        irq_in = 32'hA5A5_0F0F; commit("R2 level high");
        irq_in = 32'h0000_0000; commit("R2 level low");

        trig_we = 1'b1; trig_wdata = '1; commit("R3 edge mode setup");
        irq_in = 32'h0000_FFFF; commit("R3 rising edge");
        irq_in = 32'h0000_0000; commit("R3 latch held");
        pend_clr = '1; commit("R4 latch clear");
        irq_in = 32'h00FF_0000; commit("R3 second edge");
        pend_clr = 32'h00FF_0000; commit("R3 line high, latch cleared");
        irq_in = 32'hFF00_0000; pend_clr = '1; commit("R4 edge set wins over clear");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule